// File: doc/BRIEF.md
# PoE Start-Up Sequencer and Power Bar Meter

This block drives the indicator side of a small power-sourcing controller for Power over Ethernet. After reset it plays a fixed five-step readback of its configuration on four port indicators and an eight-segment bar graph. Each step lasts from one pulse of an external one-second tick to the next. The steps show, in turn: every LED on, the number of port controllers detected, the supply rating in 25 W units, the number of ports allowed full power, and the number of high-priority ports.

When the last step ends, the block raises a done flag that hands the port indicators to normal operation. From then on the bar graph shows consumed power against usable supply capacity. Usable capacity is 85% of the rating less a 4 W reserve. A small sequential divider computes the segment count from the live input values and refreshes it every few clock cycles. A full bar therefore warns that not even the smallest class of load can be granted power while keeping the 15% margin.

Top module: `pse_startup_meter`

## Requirements
- R1: While `rst` is high, and in the first cycles after it falls, `port_led` is 4'b1111, `meter_led` is 8'hFF and `startup_done` is 0. A reset at any time restarts the sequence at the all-on step.
- R2: Each one-cycle pulse on `sec_tick` moves the display forward by exactly one step, and the new step appears at the outputs within two clock cycles. Without a pulse the step does not change. After the fifth step, the next pulse enters normal operation.
- R3: The second step sets `port_led` to 4'b0001 (bit 0 is port 1). `meter_led` is 8'h00 when `ctrl_found` is 0, 8'h0F when it is 1, and 8'hFF when it is 2 or 3.
- R4: The third step sets `port_led` to 4'b0010 and lights floor(`supply_w`/25) segments, at most 8.
- R5: The fourth step sets `port_led` to 4'b0100 and lights `hipwr_cnt` segments. The fifth step sets `port_led` to 4'b1000 and lights `hiprio_cnt` segments. Both counts are capped at 8.
- R6: In normal operation `startup_done` is 1 and `port_led` is 0. Both hold until the next reset, whatever `sec_tick` does.
- R7: In normal operation the lit count is floor(160·`load_w` / (17·`supply_w` − 80)), capped at 8. This is exactly 8·load/(0.85·supply − 4 W). Lit segments always form a contiguous run starting at bit 0 (segment 1).
- R8: When 17·`supply_w` ≤ 80, so that the usable capacity is zero or negative, all eight segments are lit in normal operation.
- R9: After `load_w` or `supply_w` changes in normal operation, `meter_led` shows the new value within 16 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| ctrl_found | input | 2 | Number of port controllers detected |
| supply_w | input | 9 | Supply rating in watts |
| hipwr_cnt | input | 4 | Number of ports allowed full power |
| hiprio_cnt | input | 4 | Number of high-priority ports |
| load_w | input | 9 | Total consumed power in watts |
| port_led | output | 4 | Port indicator select, bit 0 is port 1 |
| meter_led | output | 8 | Bar-graph image, bit 0 is segment 1 |
| startup_done | output | 1 | High once the start-up display is over |

## Verification
The assertions assume that `sec_tick` is a single-cycle pulse, and that the power and count inputs stay steady long enough for the divider to finish a pass. The bench meets both assumptions. It drives every input on the falling clock edge, raises each tick for exactly one cycle, and holds each operand pair for twenty cycles before it samples. Counts above eight and controller counts of three are applied on purpose, so that the saturation paths are exercised with legal inputs only.

// File: rtl/pse_sm_pkg.sv
`timescale 1ns/1ps
package pse_sm_pkg;
  // display steps in order; the order is the start-up sequence
  typedef enum logic [2:0] {
    ST_ALL    = 3'd0,
    ST_CTRL   = 3'd1,
    ST_SUPPLY = 3'd2,
    ST_HIPWR  = 3'd3,
    ST_HIPRIO = 3'd4,
    ST_RUN    = 3'd5
  } step_t;
endpackage

// File: rtl/pse_sm_step.sv
`timescale 1ns/1ps
module pse_sm_step
  import pse_sm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  output step_t step
);
  always_ff @(posedge clk) begin
    if (rst)
      step <= ST_ALL;
    else if (tick && step != ST_RUN)
      step <= step_t'(step + 3'd1);
  end

  // R2: no movement without a tick
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(step));
  // R2: a tick during start-up always moves the step
  a_r2_tick_advances: assert property (@(posedge clk) disable iff (rst)
    (tick && step != ST_RUN) |=> (step != $past(step)));
  // R6: normal operation is final until reset
  a_r6_run_final: assert property (@(posedge clk) disable iff (rst)
    (step == ST_RUN) |=> (step == ST_RUN));
endmodule

// File: rtl/pse_sm_div.sv
`timescale 1ns/1ps
module pse_sm_div #(
  parameter int NW  = 17,
  parameter int QW  = 4,
  parameter int SAT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  input  logic          den_bad,
  output logic [QW-1:0] quo
);
  localparam int RW = NW + QW;
  localparam int IW = (QW > 1) ? $clog2(QW) : 1;

  logic          busy;
  logic          bad_q;
  logic [RW-1:0] rem;
  logic [RW-1:0] dsh;
  logic [IW-1:0] bitx;
  logic [QW-1:0] qacc;
  logic          ge;
  logic [QW-1:0] qnext;

  always_comb begin
    ge    = (rem >= dsh);
    qnext = qacc | (ge ? (QW'(1) << bitx) : '0);
  end

  // restoring division, one quotient bit per cycle, most significant first
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      bad_q <= 1'b0;
      rem   <= '0;
      dsh   <= '0;
      bitx  <= '0;
      qacc  <= '0;
      quo   <= QW'(SAT);
    end else if (!busy) begin
      busy  <= 1'b1;
      bad_q <= den_bad;
      rem   <= RW'(num);
      dsh   <= RW'(den) << (QW - 1);
      bitx  <= IW'(QW - 1);
      qacc  <= '0;
    end else begin
      rem <= ge ? (rem - dsh) : rem;
      if (bitx == '0) begin
        busy <= 1'b0;
        quo  <= (bad_q || qnext >= QW'(SAT)) ? QW'(SAT) : qnext;
      end else begin
        bitx <= bitx - IW'(1);
        dsh  <= dsh >> 1;
        qacc <= qnext;
      end
    end
  end

  // R7: the count handed out never exceeds the bar length
  a_r7_quo_limit: assert property (@(posedge clk) disable iff (rst)
    quo <= QW'(SAT));
  // R9: an idle divider always starts a new pass on the next cycle
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    !busy |=> busy);
endmodule

// File: rtl/pse_startup_meter.sv
`timescale 1ns/1ps
module pse_startup_meter
  import pse_sm_pkg::*;
#(
  parameter int PWR_W      = 9,
  parameter int CNT_W      = 4,
  parameter int SEG        = 8,
  parameter int PORTS      = 4,
  parameter int STEP_WATTS = 25,
  parameter int MARGIN_NUM = 17,
  parameter int MARGIN_DEN = 20,
  parameter int RESERVE_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_tick,
  input  logic [1:0]       ctrl_found,
  input  logic [PWR_W-1:0] supply_w,
  input  logic [CNT_W-1:0] hipwr_cnt,
  input  logic [CNT_W-1:0] hiprio_cnt,
  input  logic [PWR_W-1:0] load_w,
  output logic [PORTS-1:0] port_led,
  output logic [SEG-1:0]   meter_led,
  output logic             startup_done
);
  localparam int SCALE = SEG * MARGIN_DEN;
  localparam int NW    = PWR_W + $clog2(SCALE + 1);
  localparam int QW    = $clog2(SEG) + 1;
  localparam int RES   = RESERVE_W * MARGIN_DEN;

  function automatic logic [SEG-1:0] bar(input int unsigned n);
    logic [SEG-1:0] b;
    for (int i = 0; i < SEG; i++) b[i] = (i < n);
    return b;
  endfunction

  step_t          step;
  logic [NW-1:0]  prod;
  logic [NW-1:0]  num;
  logic [NW-1:0]  den;
  logic           den_bad;
  logic [QW-1:0]  quo;
  logic [SEG-1:0] ctrl_bar;

  pse_sm_step u_step (
    .clk  (clk),
    .rst  (rst),
    .tick (sec_tick),
    .step (step)
  );

  // 8*load/(0.85*supply-4) scaled to integers by MARGIN_DEN
  always_comb begin
    prod    = NW'(supply_w) * NW'(MARGIN_NUM);
    num     = NW'(load_w) * NW'(SCALE);
    den_bad = (prod <= NW'(RES));
    den     = den_bad ? '0 : (prod - NW'(RES));
  end

  pse_sm_div #(.NW(NW), .QW(QW), .SAT(SEG)) u_div (
    .clk     (clk),
    .rst     (rst),
    .num     (num),
    .den     (den),
    .den_bad (den_bad),
    .quo     (quo)
  );

  always_comb begin
    case (ctrl_found)
      2'd0:    ctrl_bar = '0;
      2'd1:    ctrl_bar = bar(SEG / 2);
      default: ctrl_bar = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_led     <= '1;
      meter_led    <= '1;
      startup_done <= 1'b0;
    end else begin
      startup_done <= 1'b0;
      case (step)
        ST_ALL: begin
          port_led  <= '1;
          meter_led <= '1;
        end
        ST_CTRL: begin
          port_led  <= PORTS'(1);
          meter_led <= ctrl_bar;
        end
        ST_SUPPLY: begin
          port_led  <= PORTS'(2);
          meter_led <= bar(int'(supply_w) / STEP_WATTS);
        end
        ST_HIPWR: begin
          port_led  <= PORTS'(4);
          meter_led <= bar(int'(hipwr_cnt));
        end
        ST_HIPRIO: begin
          port_led  <= PORTS'(8);
          meter_led <= bar(int'(hiprio_cnt));
        end
        default: begin
          port_led     <= '0;
          meter_led    <= bar(int'(quo));
          startup_done <= 1'b1;
        end
      endcase
    end
  end

  // R6: done is final and leaves the port indicators dark
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    startup_done |=> startup_done);
  a_r6_done_dark: assert property (@(posedge clk) disable iff (rst)
    startup_done |-> (port_led == '0));
  // R7: bar is contiguous from segment 1
  a_r7_contiguous: assert property (@(posedge clk) disable iff (rst)
    (meter_led & (meter_led + SEG'(1))) == '0);
  // R2: start-up selects at most one port, except in the all-on step
  a_r2_one_port: assert property (@(posedge clk) disable iff (rst)
    (port_led != '1) |-> $onehot0(port_led));
endmodule

// File: tb/pse_startup_meter_tb.sv
`timescale 1ns/1ps
module pse_startup_meter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [1:0] ctrl_found = 2'd0;
  logic [8:0] supply_w = '0;
  logic [3:0] hipwr_cnt = '0;
  logic [3:0] hiprio_cnt = '0;
  logic [8:0] load_w = '0;
  logic [3:0] port_led;
  logic [7:0] meter_led;
  logic       startup_done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pse_startup_meter dut_i (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .ctrl_found(ctrl_found),
    .supply_w(supply_w), .hipwr_cnt(hipwr_cnt), .hiprio_cnt(hiprio_cnt),
    .load_w(load_w), .port_led(port_led), .meter_led(meter_led),
    .startup_done(startup_done)
  );

  function automatic logic [7:0] exp_bar(input int n);
    int m = (n > 8) ? 8 : n;
    return 8'((16'(1) << m) - 16'(1));
  endfunction

  function automatic int exp_count(input int sup, input int ld);
    int d = 17 * sup - 80;
    int q;
    if (d <= 0) return 8;
    q = (160 * ld) / d;
    return (q > 8) ? 8 : q;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    wait_n(2);
  endtask

  initial begin
    wait_n(150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(4);
    // R1: reset state
    chk("R1 port", port_led, 4'hF);
    chk("R1 meter", meter_led, 8'hFF);
    chk("R1 done", startup_done, 0);
    rst = 1'b0;
    wait_n(3);
    chk("R1 port after release", port_led, 4'hF);
    chk("R1 meter after release", meter_led, 8'hFF);
    // R2: no tick, step holds
    wait_n(10);
    chk("R2 hold all-on", port_led, 4'hF);

    pulse_tick();
    for (int f = 0; f < 4; f++) begin
      ctrl_found = 2'(f);
      wait_n(2);
      chk("R3 port", port_led, 4'h1);
      chk("R3 meter", meter_led, (f == 0) ? 8'h00 : (f == 1) ? 8'h0F : 8'hFF);
    end

    pulse_tick();
    for (int s = 0; s <= 300; s++) begin
      supply_w = 9'(s);
      wait_n(2);
      chk("R4 port", port_led, 4'h2);
      chk("R4 meter", meter_led, exp_bar(s / 25));
    end

    pulse_tick();
    for (int c = 0; c < 16; c++) begin
      hipwr_cnt = 4'(c);
      wait_n(2);
      chk("R5 hipwr port", port_led, 4'h4);
      chk("R5 hipwr meter", meter_led, exp_bar(c));
    end

    pulse_tick();
    for (int c = 0; c < 16; c++) begin
      hiprio_cnt = 4'(c);
      wait_n(2);
      chk("R5 hiprio port", port_led, 4'h8);
      chk("R5 hiprio meter", meter_led, exp_bar(c));
    end
    wait_n(10);
    chk("R2 hold step five", port_led, 4'h8);
    chk("R2 not done yet", startup_done, 0);

    supply_w = 9'd100;
    load_w = 9'd0;
    pulse_tick();
    chk("R6 done", startup_done, 1);
    chk("R6 ports dark", port_led, 4'h0);
    for (int k = 0; k < 3; k++) pulse_tick();
    chk("R6 done after ticks", startup_done, 1);
    chk("R6 dark after ticks", port_led, 4'h0);

    // R9: latency bound from a known settled state
    wait_n(20);
    load_w = 9'd300;
    wait_n(16);
    chk("R9 refresh latency", meter_led, exp_bar(exp_count(100, 300)));

    // R7 / R8: meter sweep
    begin
      int sups[9] = '{0, 4, 5, 10, 30, 60, 150, 200, 511};
      foreach (sups[j]) begin
        for (int ld = 0; ld < 512; ld += 7) begin
          supply_w = 9'(sups[j]);
          load_w = 9'(ld);
          wait_n(20);
          if (17 * sups[j] <= 80)
            chk("R8 meter full", meter_led, 8'hFF);
          else
            chk("R7 meter", meter_led, exp_bar(exp_count(sups[j], ld)));
        end
      end
    end

    // R1: reset mid-run restarts at all-on
    rst = 1'b1;
    wait_n(1);
    rst = 1'b0;
    wait_n(2);
    chk("R1 restart port", port_led, 4'hF);
    chk("R1 restart meter", meter_led, 8'hFF);
    chk("R1 restart done", startup_done, 0);
    pulse_tick();
    chk("R2 first step after restart", port_led, 4'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule